// File: doc/BRIEF.md
# Multi-Channel Buffered PWM Timer

A register-mapped pulse-width modulation timer. A single up-counter, paced by a power-of-two prescaler, is shared by a set of edge-aligned PWM channels. Every channel therefore has the same period, which comes from one modulo register. Each channel adds its own compare value and a control register that picks its mode and output level. Software reaches all of this through a simple single-cycle read/write bus.

The modulo and compare values are double-buffered. While the counter is stopped, a write takes effect at once. While it runs, the written value waits in a buffer and is loaded when the counter wraps back to zero, so the period that is running always ends with consistent settings. Reads of these registers return the value in use, not the buffered one, so software can poll until a pending write has landed. The level and mode bits of a channel take no such detour: they act on the output in the cycle after the write.

Top module: `mcpwm_timer`

## Requirements
- R1: After reset the counter reads 0, the modulo register reads 0xFFFF, every channel value and channel control reads 0, the control register reads 0, all PWM outputs are low, offset 0x08 reads 0, and offset 0x04 returns the number of channels in bits [7:0].
- R2: The clock-mode field (bits [4:3] of the control register at offset 0x10) set to 2'b01 makes the counter run. Any other value stops it, and a stopped counter keeps its value.
- R3: The prescale field (bits [2:0] at offset 0x10) makes a running counter advance once every 2^prescale clocks.
- R4: A running counter steps from 0 up to the modulo value (offset 0x18, 16 bits), then returns to 0, so one period lasts (modulo+1) counter steps.
- R5: While the counter is stopped, a write to the modulo register or to a channel value (offset 0x24+8n) reads back the new value on the next cycle and is used at once.
- R6: While the counter runs, such a write is held and loaded when the counter wraps to 0. Until then, reads return the old value.
- R7: A channel whose control register (offset 0x20+8n) has bit 5 set, bit 4 clear and level field bits [3:2] = 2'b10 drives its output high while the counter is below the channel value, and low otherwise.
- R8: With the same mode bits and level field 2'b01, the output is the complement of R7.
- R9: Any other combination of bits 5, 4 and [3:2] (including level 2'b00) holds the output low. Changes to these bits reach the output in the cycle after the write, without waiting for a wrap.
- R10: Bit 7 of a channel control register sets when the counter advances out of a step equal to the channel value. Writing 1 to bit 7 clears it; a set in the same cycle wins.
- R11: A channel value of 0 gives an output that is always low in normal level. A channel value above the modulo value gives an output that is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_en |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The hardest case to reach from the ports is a buffered write that lands while the counter runs and must still be invisible, on readback and on the outputs, until the wrap. The bench waits for the rising edge of a channel output, which marks the counter's return to zero. It writes in the next cycle, so the write falls early in the period with many steps left. It then checks that readback shows the old value, and after a full period the new value and the new duty. A reference model that tracks the prescaler phase, the buffers and the flags is compared on every cycle, so a write that arrives late in a period is covered as well.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

   // register byte offsets
   localparam int OFS_INFO    = 'h04;
   localparam int OFS_GLOBAL  = 'h08;
   localparam int OFS_SC      = 'h10;
   localparam int OFS_CNT     = 'h14;
   localparam int OFS_MOD     = 'h18;
   localparam int CH_BASE     = 'h20;
   localparam int CH_STRIDE   = 8;
   localparam int CH_VAL_OFS  = 4;

   // field positions
   localparam int SC_PS_LSB   = 0;
   localparam int SC_CM_LSB   = 3;
   localparam int CF_FLAG     = 7;
   localparam int CF_MSB      = 5;
   localparam int CF_MSA      = 4;
   localparam int CF_LVL_LSB  = 2;

   typedef enum logic [1:0] {
      CM_STOP = 2'b00,
      CM_RUN  = 2'b01,
      CM_RSV2 = 2'b10,
      CM_RSV3 = 2'b11
   } clkmode_e;

   typedef enum logic [1:0] {
      LV_OFF  = 2'b00,
      LV_INV  = 2'b01,
      LV_NORM = 2'b10,
      LV_RSV  = 2'b11
   } level_e;

   typedef struct packed {
      logic   flag;
      logic   msb;
      logic   msa;
      level_e lvl;
   } chctl_t;

   function automatic logic chan_enabled(input chctl_t c);
      return c.msb && !c.msa && ((c.lvl == LV_NORM) || (c.lvl == LV_INV));
   endfunction

endpackage

// File: rtl/mcpwm_prescale.sv
module mcpwm_prescale #(
   parameter int PSW = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] ps,
   output logic       tick
);
   localparam int DIVW = (PSW == 0) ? 1 : ((1 << PSW) - 1);

   generate
      if (PSW == 0) begin : g_nodiv
         logic unused_nodiv;
         assign unused_nodiv = ^{clk, rst_n, ps};
         assign tick = run;
      end else begin : g_div
         logic [DIVW-1:0] div_q;
         logic [DIVW-1:0] lim;
         assign lim  = DIVW'((32'd1 << ps) - 32'd1);
         assign tick = run && (div_q >= lim);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (!run || tick)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          mod_we,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] mod_act,
   output logic          wrap
);
   logic [CW-1:0] mod_buf;

   assign wrap = tick && (cnt >= mod_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         mod_buf <= '1;
         mod_act <= '1;
      end else begin
         if (wrap)
            cnt <= '0;
         else if (tick)
            cnt <= cnt + 1'b1;

         if (mod_we)
            mod_buf <= wdata;

         if (wrap)
            mod_act <= mod_buf;
         else if (mod_we && !run)
            mod_act <= wdata;
      end
   end
endmodule

// File: rtl/mcpwm_channel.sv
module mcpwm_channel
   import mcpwm_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          wrap,
   input  logic [CW-1:0] cnt,
   input  logic          val_we,
   input  logic          ctl_we,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] val_act,
   output chctl_t        ctl,
   output logic          pwm
);
   logic [CW-1:0] val_buf;
   logic          match;
   logic          clr;
   logic          below;

   assign match = tick && (cnt == val_act);
   assign clr   = ctl_we && wdata[CF_FLAG];
   assign below = cnt < val_act;
   assign pwm   = chan_enabled(ctl) && (below ^ (ctl.lvl == LV_INV));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_buf <= '0;
         val_act <= '0;
      end else begin
         if (val_we)
            val_buf <= wdata;
         if (wrap)
            val_act <= val_buf;
         else if (val_we && !run)
            val_act <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '{flag: 1'b0, msb: 1'b0, msa: 1'b0, lvl: LV_OFF};
      end else begin
         ctl.flag <= match | (ctl.flag & ~clr);
         if (ctl_we) begin
            ctl.msb <= wdata[CF_MSB];
            ctl.msa <= wdata[CF_MSA];
            ctl.lvl <= level_e'(wdata[CF_LVL_LSB +: 2]);
         end
      end
   end
endmodule

// File: rtl/mcpwm_timer.sv
module mcpwm_timer
   import mcpwm_pkg::*;
#(
   parameter int NCH = 4,
   parameter int CW  = 16,
   parameter int PSW = 3,
   parameter int AW  = 8,
   parameter int DW  = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_en,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic [NCH-1:0] pwm_out
);
   localparam int         LAST_OFS = CH_BASE + CH_STRIDE * (NCH - 1) + CH_VAL_OFS;
   localparam logic [2:0] PS_MASK  = 3'((1 << PSW) - 1);

   generate
      if (NCH < 1 || LAST_OFS >= (1 << AW)) begin : g_bad_nch
         $error("mcpwm_timer: channel count does not fit the address space");
      end
      if (PSW < 0 || PSW > 3) begin : g_bad_psw
         $error("mcpwm_timer: prescale width must be 0 to 3");
      end
      if (CW < 8 || CW > 16) begin : g_bad_cw
         $error("mcpwm_timer: counter width must be 8 to 16");
      end
      if (DW <= CW) begin : g_bad_dw
         $error("mcpwm_timer: data width must exceed counter width");
      end
   endgenerate

   logic            wr;
   logic            sc_we;
   logic            mod_we;
   logic [2:0]      ps_q;
   clkmode_e        cm_q;
   logic            run;
   logic            tick;
   logic            wrap;
   logic [CW-1:0]   cnt;
   logic [CW-1:0]   mod_act;
   logic [CW-1:0]   wdat;
   logic [NCH-1:0]  ctl_hit;
   logic [NCH-1:0]  val_hit;
   logic [CW-1:0]   val_act [NCH];
   chctl_t          ctl     [NCH];
   logic [2*NCH-1:0] lvl_flat;
   logic            unused_hi;

   assign wr        = bus_en && bus_we;
   assign sc_we     = wr && (bus_addr == AW'(OFS_SC));
   assign mod_we    = wr && (bus_addr == AW'(OFS_MOD));
   assign run       = (cm_q == CM_RUN);
   assign wdat      = bus_wdata[CW-1:0];
   assign unused_hi = ^bus_wdata[DW-1:CW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q <= '0;
         cm_q <= CM_STOP;
      end else if (sc_we) begin
         ps_q <= bus_wdata[SC_PS_LSB +: 3] & PS_MASK;
         cm_q <= clkmode_e'(bus_wdata[SC_CM_LSB +: 2]);
      end
   end

   mcpwm_prescale #(.PSW(PSW)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .ps   (ps_q),
      .tick (tick)
   );

   mcpwm_timebase #(.CW(CW)) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (tick),
      .mod_we (mod_we),
      .wdata  (wdat),
      .cnt    (cnt),
      .mod_act(mod_act),
      .wrap   (wrap)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         assign ctl_hit[i] = bus_addr == AW'(CH_BASE + CH_STRIDE * i);
         assign val_hit[i] = bus_addr == AW'(CH_BASE + CH_STRIDE * i + CH_VAL_OFS);
         assign lvl_flat[2*i +: 2] = ctl[i].lvl;

         mcpwm_channel #(.CW(CW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .tick   (tick),
            .wrap   (wrap),
            .cnt    (cnt),
            .val_we (wr && val_hit[i]),
            .ctl_we (wr && ctl_hit[i]),
            .wdata  (wdat),
            .val_act(val_act[i]),
            .ctl    (ctl[i]),
            .pwm    (pwm_out[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(OFS_INFO))
         bus_rdata[7:0] = 8'(NCH);
      if (bus_addr == AW'(OFS_SC)) begin
         bus_rdata[SC_PS_LSB +: 3] = ps_q;
         bus_rdata[SC_CM_LSB +: 2] = cm_q;
      end
      if (bus_addr == AW'(OFS_CNT))
         bus_rdata[CW-1:0] = cnt;
      if (bus_addr == AW'(OFS_MOD))
         bus_rdata[CW-1:0] = mod_act;
      for (int i = 0; i < NCH; i++) begin
         if (ctl_hit[i]) begin
            bus_rdata[CF_FLAG]            = ctl[i].flag;
            bus_rdata[CF_MSB]             = ctl[i].msb;
            bus_rdata[CF_MSA]             = ctl[i].msa;
            bus_rdata[CF_LVL_LSB +: 2]    = ctl[i].lvl;
         end
         if (val_hit[i])
            bus_rdata[CW-1:0] = val_act[i];
      end
   end
endmodule

// File: rtl/mcpwm_checker.sv
module mcpwm_checker #(
   parameter int NCH = 4,
   parameter int CW  = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run,
   input logic            tick,
   input logic            sc_we,
   input logic [2:0]      ps_q,
   input logic [CW-1:0]   cnt,
   input logic [CW-1:0]   mod_act,
   input logic [2*NCH-1:0] lvl_flat,
   input logic [NCH-1:0]  pwm_out
);
   assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));

   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ps_q != 3'd0 && !sc_we) |=> !tick);

   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt < mod_act) |=> cnt == CW'($past(cnt) + 1'b1));

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt >= mod_act) |=> cnt == '0);

   assert_mod_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(tick && cnt >= mod_act)) |=> $stable(mod_act));

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_off
         assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_flat[2*i +: 2] == 2'b00) |-> !pwm_out[i]);
      end
   endgenerate
endmodule

bind mcpwm_timer mcpwm_checker #(.NCH(NCH), .CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .tick    (tick),
   .sc_we   (sc_we),
   .ps_q    (ps_q),
   .cnt     (cnt),
   .mod_act (mod_act),
   .lvl_flat(lvl_flat),
   .pwm_out (pwm_out)
);

// File: tb/sim_mcpwm_timer.sv
module sim_mcpwm_timer;
   localparam int NCH = 4;
   localparam int CW  = 16;
   localparam int AW  = 8;
   localparam int DW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = 8'h14;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NCH-1:0] pwm_out;

   always #5 clk = ~clk;

   mcpwm_timer #(.NCH(NCH), .CW(CW), .PSW(3), .AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out)
   );

   int  errors = 0;
   int  checks = 0;
   bit  cmp_on = 1'b0;
   bit  done   = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model
   int m_cnt, m_mod, m_mbuf, m_ps, m_mode, m_div;
   int m_val[NCH], m_vbuf[NCH], m_lvl[NCH], m_msb[NCH], m_msa[NCH], m_flag[NCH];

   function automatic bit m_pwm(input int i);
      bit en, hi;
      en = (m_msb[i] == 1) && (m_msa[i] == 0) && (m_lvl[i] == 2 || m_lvl[i] == 1);
      hi = m_cnt < m_val[i];
      return en && (hi ^ (m_lvl[i] == 1));
   endfunction

   function automatic int unsigned m_read(input int a);
      if (a == 'h04) return NCH;
      if (a == 'h10) return (m_mode << 3) | m_ps;
      if (a == 'h14) return m_cnt;
      if (a == 'h18) return m_mod;
      for (int i = 0; i < NCH; i++) begin
         if (a == 'h20 + 8*i)
            return (m_flag[i] << 7) | (m_msb[i] << 5) | (m_msa[i] << 4) | (m_lvl[i] << 2);
         if (a == 'h24 + 8*i) return m_val[i];
      end
      return 0;
   endfunction

   always @(posedge clk) begin
      bit run, tick, wrap;
      bit setf[NCH];
      bit clrf[NCH];
      int a, w;
      if (!rst_n) begin
         m_cnt = 0; m_mod = 'hFFFF; m_mbuf = 'hFFFF; m_ps = 0; m_mode = 0; m_div = 0;
         for (int i = 0; i < NCH; i++) begin
            m_val[i] = 0; m_vbuf[i] = 0; m_lvl[i] = 0; m_msb[i] = 0; m_msa[i] = 0; m_flag[i] = 0;
         end
      end else begin
         run  = (m_mode == 1);
         tick = run && (m_div >= (1 << m_ps) - 1);
         wrap = tick && (m_cnt >= m_mod);
         for (int i = 0; i < NCH; i++) begin
            setf[i] = tick && (m_cnt == m_val[i]);
            clrf[i] = 1'b0;
         end
         m_div = (!run || tick) ? 0 : m_div + 1;
         if (wrap) begin
            m_cnt = 0;
            m_mod = m_mbuf;
            for (int i = 0; i < NCH; i++) m_val[i] = m_vbuf[i];
         end else if (tick) begin
            m_cnt = m_cnt + 1;
         end
         if (bus_en && bus_we) begin
            a = int'(bus_addr);
            w = int'(bus_wdata);
            if (a == 'h10) begin
               m_ps = w & 7; m_mode = (w >> 3) & 3;
            end
            if (a == 'h18) begin
               m_mbuf = w & 'hFFFF;
               if (!run) m_mod = w & 'hFFFF;
            end
            for (int i = 0; i < NCH; i++) begin
               if (a == 'h20 + 8*i) begin
                  m_msb[i] = (w >> 5) & 1; m_msa[i] = (w >> 4) & 1; m_lvl[i] = (w >> 2) & 3;
                  clrf[i] = ((w >> 7) & 1) == 1;
               end
               if (a == 'h24 + 8*i) begin
                  m_vbuf[i] = w & 'hFFFF;
                  if (!run) m_val[i] = w & 'hFFFF;
               end
            end
         end
         for (int i = 0; i < NCH; i++)
            m_flag[i] = (setf[i] || (m_flag[i] == 1 && !clrf[i])) ? 1 : 0;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         for (int i = 0; i < NCH; i++)
            check($sformatf("R7 R8 R9 R11 model pwm ch%0d", i), 32'(pwm_out[i]), 32'(m_pwm(i)));
         check($sformatf("R5 R6 R10 model read @%0h", bus_addr), bus_rdata, m_read(int'(bus_addr)));
      end
   end

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); #2;
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #2;
      bus_en = 1'b0; bus_we = 1'b0; bus_addr = 8'h14;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk); #2;
      bus_addr = a;
      @(negedge clk);
      v = bus_rdata;
   endtask

   task automatic count_high(input int ch, input int n, output int c);
      c = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out[ch]) c++;
      end
   endtask

   task automatic count_rise(input int ch, input int n, output int c);
      logic prev;
      c = 0;
      @(negedge clk);
      prev = pwm_out[ch];
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out[ch] && !prev) c++;
         prev = pwm_out[ch];
      end
   endtask

   task automatic wait_rise(input int ch);
      logic prev;
      @(negedge clk);
      prev = pwm_out[ch];
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (pwm_out[ch] && !prev) break;
         prev = pwm_out[ch];
      end
   endtask

   initial begin
      logic [DW-1:0] v, v2;
      int c;
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;

      // R1 reset state
      bus_rd(8'h04, v); check("R1 channel count", v, NCH);
      bus_rd(8'h08, v); check("R1 global reads zero", v, 0);
      bus_rd(8'h10, v); check("R1 control", v, 0);
      bus_rd(8'h14, v); check("R1 counter", v, 0);
      bus_rd(8'h18, v); check("R1 modulo", v, 32'hFFFF);
      bus_rd(8'h20, v); check("R1 ch0 control", v, 0);
      bus_rd(8'h24, v); check("R1 ch0 value", v, 0);
      check("R1 outputs low", 32'(pwm_out), 0);

      // R5 stopped writes take effect at once
      bus_wr(8'h18, 9);
      bus_rd(8'h18, v); check("R5 modulo immediate", v, 9);
      bus_wr(8'h24, 4); bus_wr(8'h2C, 7); bus_wr(8'h34, 0); bus_wr(8'h3C, 12);
      bus_rd(8'h24, v); check("R5 ch0 value immediate", v, 4);
      bus_rd(8'h3C, v); check("R5 ch3 value immediate", v, 12);
      repeat (5) @(negedge clk);
      bus_rd(8'h14, v); check("R2 stopped counter holds", v, 0);

      bus_wr(8'h20, 32'h28); bus_wr(8'h28, 32'h24);
      bus_wr(8'h30, 32'h28); bus_wr(8'h38, 32'h28);
      bus_wr(8'h10, 32'h08);
      count_high(0, 10, c); check("R7 normal duty ch0", c, 4);
      count_high(1, 10, c); check("R8 inverted duty ch1", c, 3);
      count_high(2, 10, c); check("R11 zero value never high", c, 0);
      count_high(3, 10, c); check("R11 value above modulo always high", c, 10);

      // R3 prescale by 4
      bus_wr(8'h10, 32'h0A);
      repeat (50) @(negedge clk);
      count_high(0, 40, c); check("R3 prescaled duty ch0", c, 16);
      count_high(1, 40, c); check("R3 prescaled inverted ch1", c, 12);
      count_rise(0, 120, c); check("R4 period of (mod+1) steps", c, 3);

      // R6 buffered writes while running
      wait_rise(0);
      bus_wr(8'h24, 2);
      bus_wr(8'h18, 4);
      bus_rd(8'h24, v); check("R6 value still old", v, 4);
      bus_rd(8'h18, v); check("R6 modulo still old", v, 9);
      repeat (45) @(negedge clk);
      bus_rd(8'h24, v); check("R6 value loaded at wrap", v, 2);
      bus_rd(8'h18, v); check("R6 modulo loaded at wrap", v, 4);
      repeat (25) @(negedge clk);
      count_high(0, 20, c); check("R6 new duty ch0", c, 8);
      count_high(3, 20, c); check("R11 above new modulo", c, 20);

      // R9 disable and immediate level changes
      bus_wr(8'h20, 32'h20);
      count_high(0, 20, c); check("R9 level off holds low", c, 0);
      bus_wr(8'h28, 32'h28);
      count_high(1, 20, c); check("R9 inverted to normal at once", c, 20);
      bus_wr(8'h38, 32'h38);
      count_high(3, 20, c); check("R9 both mode bits disables", c, 0);

      // R10 flag, R2 stop
      bus_wr(8'h10, 32'h00);
      bus_rd(8'h20, v); check("R10 flag set after match", v, 32'hA0);
      bus_rd(8'h38, v); check("R10 no match no flag", v, 32'h38);
      bus_rd(8'h14, v);
      repeat (10) @(negedge clk);
      bus_rd(8'h14, v2); check("R2 stopped counter stable", v2, v);
      bus_wr(8'h20, 32'hA0);
      bus_rd(8'h20, v); check("R10 write one clears flag", v, 32'h20);

      // R5 stopped writes again, R9 immediate enable
      bus_wr(8'h24, 9);
      bus_rd(8'h24, v); check("R5 stopped value write", v, 9);
      bus_wr(8'h18, 15);
      bus_rd(8'h18, v); check("R5 stopped modulo write", v, 15);
      bus_wr(8'h20, 32'h28);
      check("R9 enable acts next cycle", 32'(pwm_out[0]), 1);

      cmp_on = 1'b0;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule